// File: doc/BRIEF.md
# Dual-Port RAM with Width Matching

A true dual-port memory with a fixed store of 16384 data bits and 2048 parity bits. Each port has its own clock, enable, write enable, address, write data and read data. Each port picks its width at elaboration from the set 1, 2, 4, 9, 18 and 36 bits. The address width follows from that choice, so both ports always cover the whole store.

A word written through one port can be read through the other at any legal width. Several narrow words are joined into one wide word, and one wide word is split into narrow words. The 9, 18 and 36-bit widths also carry one parity bit per data byte. The 1, 2 and 4-bit widths see only data bits.

Every enabled cycle is a read. When write enable is also high, the read returns the contents from before the write. The contents start at zero. Reset clears only the read registers.

Top module: `wm_dpram`

## Requirements
- R1: Legal widths are 1, 2, 4, 9, 18 and 36 bits. Any other width stops elaboration with a fatal error. The data bits per word are 1, 2, 4, 8, 16 and 32 respectively, and the rest are parity bits. The address width is 14 minus log2 of the data-bit count. Addresses up to the top one (2047 at 9 bits, 511 at 36 bits, 8191 at 2 bits, 4095 at 4 bits) reach the last bits of the store.
- R2: On a clock edge with enable and write enable both high, the word on the data input is stored. The read data output shows the word held at that address before the write (read-first). A later read returns the new word.
- R3: On a clock edge with enable high and write enable low, the read data output takes the word stored at the address. It is valid after that edge and held until the next enabled edge.
- R4: On a clock edge with enable low, nothing is written, even if write enable is high, and the read data output holds its value.
- R5: The active-low asynchronous reset `rst_ni` clears both read data outputs to zero at once. Stored contents are kept.
- R6: Data bit j of the word at address a, on a port with D data bits, is store data bit a*D+j. When narrow words are joined into a wide one, the lowest narrow address lands in the least significant bits.
- R7: A wide word read through a narrow port splits the same way. Narrow address a returns wide data bits (a mod (32/D))*D upward, taken from the word that covers it.
- R8: On 9, 18 and 36-bit ports the data bits sit in the low bits of the word and the parity bits sit above them. Parity bit k of the word at address a, on a port with P parity bits, is store parity bit a*P+k. So the parity bit of a byte follows that byte across widths.
- R9: The ports work independently. Writes from both ports on the same cycle to different bits of the same 32-bit row both take effect.
- R10: Before any write, every location reads as zero.
- R11: A write changes only the bits of its own word. Other words in the same row keep their data and parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| rst_ni | input | 1 | Active-low asynchronous reset of both read registers |
| en_a_i | input | 1 | Port A enable |
| we_a_i | input | 1 | Port A write enable |
| addr_a_i | input | 14-log2(data bits of WIDTH_A) | Port A word address |
| din_a_i | input | WIDTH_A | Port A write data, parity above data |
| dout_a_o | output | WIDTH_A | Port A read data, parity above data |
| clk_b_i | input | 1 | Port B clock |
| en_b_i | input | 1 | Port B enable |
| we_b_i | input | 1 | Port B write enable |
| addr_b_i | input | 14-log2(data bits of WIDTH_B) | Port B word address |
| din_b_i | input | WIDTH_B | Port B write data, parity above data |
| dout_b_o | output | WIDTH_B | Port B read data, parity above data |

## Verification
Every operation has a latency of one edge. The bench changes inputs on the falling edge and lets one rising edge act on them. It samples the read data on the next falling edge, which is where both the read-first value of a write and the result of a plain read are due. A write made by one port is visible to the other port on its next enabled edge, so each cross-width check is a separate operation after the write. Reset is asynchronous, so its effect is sampled a moment after `rst_ni` falls, with no clock edge needed.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int CAP_LOG2 = 14;
  localparam int ROW_DATA = 32;
  localparam int ROW_PAR  = ROW_DATA / 8;
  localparam int ROW_W    = ROW_DATA + ROW_PAR;
  localparam int ROWS     = (1 << CAP_LOG2) / ROW_DATA;
  localparam int ROW_AW   = $clog2(ROWS);

  typedef logic [ROW_W-1:0] row_t;

  function automatic bit width_ok(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
  endfunction

  function automatic int data_bits(int w);
    case (w)
      9:       return 8;
      18:      return 16;
      36:      return 32;
      default: return (w < 1) ? 1 : w;
    endcase
  endfunction

  function automatic int par_bits(int w);
    return (w == 9 || w == 18 || w == 36) ? data_bits(w) / 8 : 0;
  endfunction

  function automatic int addr_bits(int w);
    return CAP_LOG2 - $clog2(data_bits(w));
  endfunction
endpackage

// File: rtl/wm_merge.sv
// Picks, per bit, whichever port wrote that bit most recently.
module wm_merge
  import wm_pkg::*;
#(
  parameter int SIDE = 0
) (
  input  row_t own_mem_i,
  input  row_t oth_mem_i,
  input  row_t own_tog_i,
  input  row_t oth_tog_i,
  output row_t row_o
);
  row_t own_latest;

  // side 0 owns a bit when toggles match, side 1 when they differ
  always_comb begin
    if (SIDE == 0) own_latest = ~(own_tog_i ^ oth_tog_i);
    else           own_latest =   own_tog_i ^ oth_tog_i;
    row_o = (own_mem_i & own_latest) | (oth_mem_i & ~own_latest);
  end
endmodule

// File: rtl/wm_port.sv
module wm_port
  import wm_pkg::*;
#(
  parameter int W    = 9,
  parameter int SIDE = 0,
  localparam int DW  = data_bits(W),
  localparam int PW  = par_bits(W),
  localparam int AW  = addr_bits(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output row_t          mem_o [ROWS],
  output row_t          tog_o [ROWS],
  input  row_t          oth_mem_i [ROWS],
  input  row_t          oth_tog_i [ROWS]
);
  localparam int LANES = ROW_DATA / DW;
  localparam int LB    = $clog2(LANES);

  row_t mem_q [ROWS] = '{default: '0};
  row_t tog_q [ROWS] = '{default: '0};

  logic [ROW_AW-1:0] row_idx;
  logic [5:0]        lane;
  row_t              din_pad, wrow, mask, tog_new, merged, rd_pad;
  logic [W-1:0]      dout_q;

  assign row_idx = ROW_AW'(addr_i >> LB);
  assign lane    = 6'(addr_i) & 6'(LANES - 1);
  assign din_pad = ROW_W'(din_i);
  assign tog_new = (SIDE == 0) ? oth_tog_i[row_idx] : ~oth_tog_i[row_idx];

  always_comb begin
    mask = '0;
    wrow = '0;
    for (int k = 0; k < DW; k++) begin
      mask[int'(lane)*DW + k] = 1'b1;
      wrow[int'(lane)*DW + k] = din_pad[k];
    end
    for (int k = 0; k < PW; k++) begin
      mask[ROW_DATA + int'(lane)*PW + k] = 1'b1;
      wrow[ROW_DATA + int'(lane)*PW + k] = din_pad[DW + k];
    end
  end

  wm_merge #(.SIDE(SIDE)) u_merge (
    .own_mem_i (mem_q[row_idx]),
    .oth_mem_i (oth_mem_i[row_idx]),
    .own_tog_i (tog_q[row_idx]),
    .oth_tog_i (oth_tog_i[row_idx]),
    .row_o     (merged)
  );

  always_comb begin
    rd_pad = '0;
    for (int k = 0; k < DW; k++) rd_pad[k] = merged[int'(lane)*DW + k];
    for (int k = 0; k < PW; k++) rd_pad[DW + k] = merged[ROW_DATA + int'(lane)*PW + k];
  end

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) begin
      mem_q[row_idx] <= (mem_q[row_idx] & ~mask) | wrow;
      tog_q[row_idx] <= (tog_q[row_idx] & ~mask) | (tog_new & mask);
    end
  end

  // read-first: merged still holds pre-write contents at this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= '0;
    else if (en_i) dout_q <= rd_pad[W-1:0];
  end

  assign dout_o = dout_q;
  assign mem_o  = mem_q;
  assign tog_o  = tog_q;

  always @(posedge clk_i) begin
    if (!rst_ni) a_r5_reset_clear: assert (dout_q == '0);
  end

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dout_q));

  a_r4_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && we_i) |=> mem_q[$past(row_idx)] == $past(mem_q[row_idx]));

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |=> (mem_q[$past(row_idx)] & $past(mask)) == $past(wrow));

  a_r11_lane_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |=>
      (mem_q[$past(row_idx)] & ~$past(mask)) == ($past(mem_q[row_idx]) & ~$past(mask)));
endmodule

// File: rtl/wm_dpram.sv
module wm_dpram
  import wm_pkg::*;
#(
  parameter int WIDTH_A = 9,
  parameter int WIDTH_B = 36
) (
  input  logic                               clk_a_i,
  input  logic                               rst_ni,
  input  logic                               en_a_i,
  input  logic                               we_a_i,
  input  logic [wm_pkg::addr_bits(WIDTH_A)-1:0] addr_a_i,
  input  logic [WIDTH_A-1:0]                 din_a_i,
  output logic [WIDTH_A-1:0]                 dout_a_o,
  input  logic                               clk_b_i,
  input  logic                               en_b_i,
  input  logic                               we_b_i,
  input  logic [wm_pkg::addr_bits(WIDTH_B)-1:0] addr_b_i,
  input  logic [WIDTH_B-1:0]                 din_b_i,
  output logic [WIDTH_B-1:0]                 dout_b_o
);
  initial begin
    if (!width_ok(WIDTH_A) || !width_ok(WIDTH_B))
      $fatal(1, "wm_dpram: illegal port width A=%0d B=%0d", WIDTH_A, WIDTH_B);
  end

  row_t mem_a [ROWS];
  row_t tog_a [ROWS];
  row_t mem_b [ROWS];
  row_t tog_b [ROWS];

  wm_port #(.W(WIDTH_A), .SIDE(0)) u_port_a (
    .clk_i     (clk_a_i),
    .rst_ni    (rst_ni),
    .en_i      (en_a_i),
    .we_i      (we_a_i),
    .addr_i    (addr_a_i),
    .din_i     (din_a_i),
    .dout_o    (dout_a_o),
    .mem_o     (mem_a),
    .tog_o     (tog_a),
    .oth_mem_i (mem_b),
    .oth_tog_i (tog_b)
  );

  wm_port #(.W(WIDTH_B), .SIDE(1)) u_port_b (
    .clk_i     (clk_b_i),
    .rst_ni    (rst_ni),
    .en_i      (en_b_i),
    .we_i      (we_b_i),
    .addr_i    (addr_b_i),
    .din_i     (din_b_i),
    .dout_o    (dout_b_o),
    .mem_o     (mem_b),
    .tog_o     (tog_b),
    .oth_mem_i (mem_a),
    .oth_tog_i (tog_a)
  );
endmodule

// File: tb/wm_dpram_test.sv
module wm_dpram_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        port;
    logic        we;
    logic [13:0] addr;
    logic [35:0] din;
    logic [35:0] exp;
    logic [3:0]  req;
  } vec_t;

  // uut: port A 9 bits (byte + parity), port B 36 bits (4 bytes + 4 parity)
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 14'd0, 36'h0,         36'h0,         4'd10}, // R10 power-up zero
    '{1'b0, 1'b1, 14'd0, 36'h1AA,       36'h0,         4'd2},  // R2
    '{1'b0, 1'b1, 14'd1, 36'h055,       36'h0,         4'd2},  // R2
    '{1'b0, 1'b1, 14'd2, 36'h1F0,       36'h0,         4'd2},  // R2
    '{1'b0, 1'b1, 14'd3, 36'h00F,       36'h0,         4'd2},  // R2
    '{1'b1, 1'b0, 14'd0, 36'h0,         36'h50FF055AA, 4'd6},  // R6 R8 combine
    '{1'b0, 1'b0, 14'd2, 36'h0,         36'h1F0,       4'd3},  // R3
    '{1'b1, 1'b1, 14'd1, 36'hA12345678, 36'h0,         4'd2},  // R2
    '{1'b0, 1'b0, 14'd4, 36'h0,         36'h078,       4'd7},  // R7 split
    '{1'b0, 1'b0, 14'd5, 36'h0,         36'h156,       4'd8},  // R8 parity follows byte
    '{1'b0, 1'b0, 14'd7, 36'h0,         36'h112,       4'd7},  // R7
    '{1'b0, 1'b1, 14'd6, 36'h0CC,       36'h034,       4'd2},  // R2 read-first
    '{1'b1, 1'b0, 14'd1, 36'h0,         36'hA12CC5678, 4'd11}, // R11 neighbours kept
    '{1'b1, 1'b1, 14'd1, 36'h0FFFFFFFF, 36'hA12CC5678, 4'd2},  // R2
    '{1'b1, 1'b0, 14'd1, 36'h0,         36'h0FFFFFFFF, 4'd3}   // R3
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        en_a = 0, we_a = 0, en_b = 0, we_b = 0;
  logic [10:0] addr_a = '0;
  logic [8:0]  addr_b = '0;
  logic [8:0]  din_a = '0, dout_a;
  logic [35:0] din_b = '0, dout_b;

  logic        en_na = 0, we_na = 0, en_nb = 0, we_nb = 0;
  logic [12:0] addr_na = '0;
  logic [11:0] addr_nb = '0;
  logic [1:0]  din_na = '0, dout_na;
  logic [3:0]  din_nb = '0, dout_nb;

  int checks = 0;
  int errors = 0;

  wm_dpram #(.WIDTH_A(9), .WIDTH_B(36)) uut (
    .clk_a_i(clk), .rst_ni(rst_ni), .en_a_i(en_a), .we_a_i(we_a),
    .addr_a_i(addr_a), .din_a_i(din_a), .dout_a_o(dout_a),
    .clk_b_i(clk), .en_b_i(en_b), .we_b_i(we_b),
    .addr_b_i(addr_b), .din_b_i(din_b), .dout_b_o(dout_b)
  );

  wm_dpram #(.WIDTH_A(2), .WIDTH_B(4)) uut_n (
    .clk_a_i(clk), .rst_ni(rst_ni), .en_a_i(en_na), .we_a_i(we_na),
    .addr_a_i(addr_na), .din_a_i(din_na), .dout_a_o(dout_na),
    .clk_b_i(clk), .en_b_i(en_nb), .we_b_i(we_nb),
    .addr_b_i(addr_nb), .din_b_i(din_nb), .dout_b_o(dout_nb)
  );

  task automatic check(input logic [35:0] act, input logic [35:0] exp,
                       input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called just after a falling edge; ends just after the next falling edge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    en_a = 0; we_a = 0; en_b = 0; we_b = 0;
    en_na = 0; we_na = 0; en_nb = 0; we_nb = 0;
  endtask

  task automatic op(input vec_t v);
    if (!v.port) begin
      en_a = 1; we_a = v.we; addr_a = v.addr[10:0]; din_a = v.din[8:0];
    end else begin
      en_b = 1; we_b = v.we; addr_b = v.addr[8:0]; din_b = v.din;
    end
    cycle();
    if (!v.port) check({27'h0, dout_a}, v.exp, int'(v.req), "vector port A");
    else         check(dout_b, v.exp, int'(v.req), "vector port B");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] held;
    #1;
    check({27'h0, dout_a}, 36'h0, 5, "R5 reset port A");
    check(dout_b, 36'h0, 5, "R5 reset port B");
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) op(VECS[i]);

    // R5: async clear of outputs, memory kept
    rst_ni = 0;
    #1;
    check(dout_b, 36'h0, 5, "R5 async clear");
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    en_b = 1; addr_b = 9'd1;
    cycle();
    check(dout_b, 36'h0FFFFFFFF, 5, "R5 contents kept");

    // R4: disabled write is ignored, output held
    en_a = 1; addr_a = 11'd2;
    cycle();
    held = dout_a;
    en_a = 0; we_a = 1; addr_a = 11'd0; din_a = 9'h000;
    cycle();
    check({27'h0, dout_a}, {27'h0, held}, 4, "R4 output held");
    en_a = 1; addr_a = 11'd0;
    cycle();
    check({27'h0, dout_a}, 36'h1AA, 4, "R4 no write");

    // R1: top addresses on a 9/36 pair
    en_a = 1; we_a = 1; addr_a = 11'd2047; din_a = 9'h1FF;
    cycle();
    en_b = 1; addr_b = 9'd511;
    cycle();
    check(dout_b, 36'h8FF000000, 1, "R1 top address 9->36");

    // R1: top addresses on a 2/4 pair
    en_na = 1; we_na = 1; addr_na = 13'd8191; din_na = 2'b10;
    cycle();
    en_nb = 1; addr_nb = 12'd4095;
    cycle();
    check({32'h0, dout_nb}, 36'h8, 1, "R1 top address 2->4");

    // R9: same-cycle writes to different bits of one row
    en_na = 1; we_na = 1; addr_na = 13'd0; din_na = 2'b11;
    en_nb = 1; we_nb = 1; addr_nb = 12'd1; din_nb = 4'hA;
    cycle();
    en_nb = 1; addr_nb = 12'd0;
    cycle();
    check({32'h0, dout_nb}, 36'h3, 9, "R9 port A write kept (R6 combine)");
    en_nb = 1; addr_nb = 12'd1;
    cycle();
    check({32'h0, dout_nb}, 36'hA, 9, "R9 port B write kept");
    en_na = 1; addr_na = 13'd2;
    cycle();
    check({34'h0, dout_na}, 36'h2, 7, "R7 split 4->2");
    en_na = 1; addr_na = 13'd3;
    cycle();
    check({34'h0, dout_na}, 36'h2, 7, "R7 split upper pair");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule